// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block takes in 8-bit frames on a two-wire link made of a serial data line and a bit clock. The bit clock can come from outside on `sck_in`. It can also be made inside by a programmable divider and driven out on `sck_out`. Data is sampled on each rising edge of the bit clock, least significant bit first. A frame has no start, stop or parity bits. The bits build up in a shift register that is kept apart from the data register that software reads.

When the eighth bit arrives, the frame moves into the data register and a full flag is set. If the full flag is still set when the next frame ends, that frame is dropped and an overrun flag is set instead. Reception then pauses until software clears the overrun flag. A small register port gives software the received byte, the two flags (cleared by writing 0), a control word and the divider setting. A single enable gates both level interrupt outputs.

Top module: `csync_rx`

## Requirements
- R1: After reset, the data register reads 0x00, status reads 0x00, control reads 0x00, both interrupt outputs are 0 and `sck_out` is 1.
- R2: With control bit 0 (receive enable) set, each rising edge of the selected bit clock samples `sdata_in`. The first sampled bit lands in data bit 0 and the eighth in data bit 7.
- R3: With control bit 2 (external clock select) at 0 and reception running, `sck_out` spends exactly DIV+1 clock cycles low and DIV+1 cycles high, where DIV is register 3. When reception is not running, `sck_out` goes back to 1 and stays there.
- R4: When a frame ends while status bit 0 (full) is 0, the byte appears at register 0 and status bit 0 becomes 1.
- R5: `rx_irq` equals control bit 1 (interrupt enable) AND full AND NOT overrun, as a level.
- R6: When a frame ends while full is 1, status bit 1 (overrun) becomes 1, register 0 keeps its previous byte, and full stays 1.
- R7: `err_irq` equals interrupt enable AND overrun. It is never high in the same cycle as `rx_irq`.
- R8: While overrun is 1, no frame is taken, register 0 does not change, and the internal clock stays high, until overrun is cleared.
- R9: A write to register 1 clears each flag whose bit in the written data is 0. A written 1 leaves that flag unchanged.
- R10: While receive enable is 0, no bits are sampled and the bit count is reset, so a frame cut short by disabling is thrown away.
- R11: With interrupt enable at 0, both interrupt outputs stay 0 whatever the flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_in | input | 1 | External bit clock |
| sdata_in | input | 1 | Serial data |
| sck_out | output | 1 | Internally generated bit clock, idle high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 divider |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| rx_irq | output | 1 | Receive-data interrupt level |
| err_irq | output | 1 | Overrun interrupt level |

## Verification
The bench builds the block with DIV_W=8, SYNC_STAGES=2 and DIV_RST=3. For external-clock frames it uses a 16-cycle bit period, well clear of the two-stage synchronizer. It programs the divider to random values from 2 to 5. At a divider of 2 the half period is three cycles, the shortest that still lets data changed at a falling edge pass the synchronizer before the next rise, so back-to-back internal frames and overrun suspension are tested at the tightest workable timing.

// File: rtl/csync_rx_pkg.sv
package csync_rx_pkg;

    localparam int FRAME_BITS = 8;
    localparam int BCNT_W     = $clog2(FRAME_BITS);
    localparam int REG_W      = 8;

    typedef logic [FRAME_BITS-1:0] frame_t;

    typedef enum logic [1:0] {
        ADDR_DATA = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_CTRL = 2'd2,
        ADDR_DIV  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic ext_clk;
        logic int_en;
        logic rx_en;
    } ctrl_t;

    typedef struct packed {
        logic ovr;
        logic full;
    } stat_t;

    function automatic frame_t shift_in(frame_t cur, logic bit_in);
        return {bit_in, cur[FRAME_BITS-1:1]};
    endfunction

endpackage

// File: rtl/csync_rx_clkgen.sv
module csync_rx_clkgen
    import csync_rx_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ext_sel,
    input  logic [DIV_W-1:0] div,
    input  logic             sck_in,
    input  logic             sdata_in,
    output logic             sck_out,
    output logic             sample,
    output logic             sample_bit
);

    logic [SYNC_STAGES:0]   sck_sync;
    logic [SYNC_STAGES-1:0] dat_sync;
    logic [DIV_W-1:0]       cnt;
    logic                   sck_q;
    logic                   int_run;
    logic                   ext_rise;
    logic                   int_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sync <= '1;
            dat_sync <= '0;
        end else begin
            sck_sync <= {sck_sync[SYNC_STAGES-1:0], sck_in};
            dat_sync <= {dat_sync[SYNC_STAGES-2:0], sdata_in};
        end
    end

    assign int_run  = run && !ext_sel;
    assign ext_rise = sck_sync[SYNC_STAGES-1] && !sck_sync[SYNC_STAGES];
    assign int_rise = int_run && (cnt == div) && !sck_q;

    always_ff @(posedge clk) begin
        if (rst || !int_run) begin
            cnt   <= '0;
            sck_q <= 1'b1;
        end else if (cnt == div) begin
            cnt   <= '0;
            sck_q <= !sck_q;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign sck_out    = sck_q;
    assign sample     = ext_sel ? (run && ext_rise) : int_rise;
    assign sample_bit = dat_sync[SYNC_STAGES-1];

    AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !int_run |=> sck_q); // R3

    AST_SCK_HOLD_MIDPHASE: assert property (@(posedge clk) disable iff (rst)
        (int_run && $past(int_run) && cnt != div) |=> (sck_q == $past(sck_q))); // R3

endmodule

// File: rtl/csync_rx_shifter.sv
module csync_rx_shifter
    import csync_rx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hold,
    input  logic   sample,
    input  logic   sample_bit,
    output logic   frame_done,
    output frame_t frame_data
);

    frame_t            shreg;
    logic [BCNT_W-1:0] bcnt;

    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(FRAME_BITS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            bcnt  <= '0;
        end else if (hold) begin
            bcnt <= '0;
        end else if (sample) begin
            shreg <= shift_in(shreg, sample_bit);
            bcnt  <= (bcnt == LAST_BIT) ? '0 : bcnt + 1'b1;
        end
    end

    assign frame_done = !hold && sample && (bcnt == LAST_BIT);
    assign frame_data = shift_in(shreg, sample_bit);

    AST_COUNT_CLEARED_ON_HOLD: assert property (@(posedge clk) disable iff (rst)
        hold |=> (bcnt == '0)); // R10

endmodule

// File: rtl/csync_rx_regs.sv
module csync_rx_regs
    import csync_rx_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             frame_done,
    input  frame_t           frame_data,
    output ctrl_t            ctrl,
    output stat_t            stat,
    output logic [DIV_W-1:0] div,
    output logic             rx_irq,
    output logic             err_irq
);

    frame_t    data_q;
    stat_t     stat_n;
    logic      load;
    reg_addr_e addr;

    assign addr = reg_addr_e'(reg_addr);

    always_comb begin
        stat_n = stat;
        load   = 1'b0;
        if (reg_wr && addr == ADDR_STAT) begin
            if (!reg_wdata[0]) stat_n.full = 1'b0;
            if (!reg_wdata[1]) stat_n.ovr  = 1'b0;
        end
        if (frame_done) begin
            if (stat.full) begin
                stat_n.ovr = 1'b1;
            end else begin
                stat_n.full = 1'b1;
                load        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            div    <= DIV_W'(DIV_RST);
            stat   <= '0;
            data_q <= '0;
        end else begin
            stat <= stat_n;
            if (load) data_q <= frame_data;
            if (reg_wr && addr == ADDR_CTRL) ctrl <= ctrl_t'(reg_wdata[2:0]);
            if (reg_wr && addr == ADDR_DIV)  div  <= reg_wdata[DIV_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (addr)
            ADDR_DATA: reg_rdata = data_q;
            ADDR_STAT: reg_rdata[1:0] = stat;
            ADDR_CTRL: reg_rdata[2:0] = ctrl;
            ADDR_DIV:  reg_rdata[DIV_W-1:0] = div;
        endcase
    end

    assign rx_irq  = ctrl.int_en && stat.full && !stat.ovr;
    assign err_irq = ctrl.int_en && stat.ovr;

    AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !stat.full) |=> (stat.full && data_q == $past(frame_data))); // R4

    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
        (frame_done && stat.full) |=> (stat.ovr && $stable(data_q))); // R6

    AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rx_irq && err_irq)); // R7

endmodule

// File: rtl/csync_rx.sv
module csync_rx
    import csync_rx_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int DIV_RST     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_in,
    input  logic       sdata_in,
    output logic       sck_out,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       rx_irq,
    output logic       err_irq
);

    ctrl_t            ctrl;
    stat_t            stat;
    logic [DIV_W-1:0] div;
    logic             run;
    logic             sample;
    logic             sample_bit;
    logic             frame_done;
    frame_t           frame_data;

    assign run = ctrl.rx_en && !stat.ovr;

    csync_rx_clkgen #(
        .DIV_W      (DIV_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .ext_sel   (ctrl.ext_clk),
        .div       (div),
        .sck_in    (sck_in),
        .sdata_in  (sdata_in),
        .sck_out   (sck_out),
        .sample    (sample),
        .sample_bit(sample_bit)
    );

    csync_rx_shifter u_shifter (
        .clk       (clk),
        .rst       (rst),
        .hold      (!run),
        .sample    (sample),
        .sample_bit(sample_bit),
        .frame_done(frame_done),
        .frame_data(frame_data)
    );

    csync_rx_regs #(
        .DIV_W  (DIV_W),
        .DIV_RST(DIV_RST)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .frame_done(frame_done),
        .frame_data(frame_data),
        .ctrl      (ctrl),
        .stat      (stat),
        .div       (div),
        .rx_irq    (rx_irq),
        .err_irq   (err_irq)
    );

    AST_NO_FRAME_WHILE_OVR: assert property (@(posedge clk) disable iff (rst)
        stat.ovr |-> !frame_done); // R8

    AST_NO_FRAME_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !ctrl.rx_en |-> !frame_done); // R10

endmodule

// File: tb/csync_rx_test.sv
module csync_rx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck_in = 1'b1;
    logic       sdata_in = 1'b0;
    logic       sck_out;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       rx_irq;
    logic       err_irq;

    int checks = 0;
    int failures = 0;

    always #2 clk = !clk;

    csync_rx #(.DIV_W(8), .DIV_RST(3), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .sck_in(sck_in), .sdata_in(sdata_in),
        .sck_out(sck_out), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_irq(rx_irq), .err_irq(err_irq)
    );

    function automatic logic exp_rx(logic ie, logic [1:0] st);
        return ie && st[0] && !st[1];
    endfunction

    function automatic logic exp_err(logic ie, logic [1:0] st);
        return ie && st[1];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic ext_bits(logic [7:0] b, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sck_in = 1'b0; sdata_in = b[i];
            repeat (8) @(negedge clk);
            sck_in = 1'b1;
            repeat (8) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_sck(logic lvl);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sck_out !== lvl && n < 200);
    endtask

    task automatic int_frame(logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            wait_sck(1'b0);
            sdata_in = b[i];
            wait_sck(1'b1);
        end
    endtask

    task automatic check_flags(string req, logic ie, logic [1:0] st_exp);
        logic [7:0] v;
        rd(2'd1, v);
        check({req, " status"}, v, {6'b0, st_exp});
        check({req, " rx_irq"}, rx_irq, exp_rx(ie, st_exp));
        check({req, " err_irq"}, err_irq, exp_err(ie, st_exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] b1, b2, b3;
        void'($urandom(32'h5eed));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); check("R1 data", v, 8'h00);
        rd(2'd2, v); check("R1 ctrl", v, 8'h00);
        check_flags("R1", 1'b0, 2'b00);
        check("R1 sck_out", sck_out, 1'b1);

        // R2 R4 R5 R9: external clock, random bytes
        wr(2'd2, 8'h07);
        for (int k = 0; k < 6; k++) begin
            b1 = 8'($urandom);
            if (k == 0) b1 = 8'h01;
            if (k == 1) b1 = 8'h80;
            ext_bits(b1, 8);
            rd(2'd0, v); check("R2 data lsb-first", v, b1);
            check_flags("R4 R5", 1'b1, 2'b01);
            wr(2'd1, 8'h00);
            check_flags("R9 clear", 1'b1, 2'b00);
        end

        // R9 writing ones has no effect
        b1 = 8'($urandom);
        ext_bits(b1, 8);
        wr(2'd1, 8'h03);
        check_flags("R9 write-one", 1'b1, 2'b01);

        // R6 R7 overrun
        b2 = ~b1;
        ext_bits(b2, 8);
        rd(2'd0, v); check("R6 data kept", v, b1);
        check_flags("R6 R7", 1'b1, 2'b11);

        // R8 frame ignored while overrun
        b3 = 8'($urandom) ^ 8'h5a;
        ext_bits(b3, 8);
        rd(2'd0, v); check("R8 data frozen", v, b1);
        check_flags("R8", 1'b1, 2'b11);

        // R9 clear overrun alone
        wr(2'd1, 8'h01);
        check_flags("R9 ovr only", 1'b1, 2'b01);
        wr(2'd1, 8'h00);
        ext_bits(b3, 8);
        rd(2'd0, v); check("R8 resume", v, b3);
        wr(2'd1, 8'h00);

        // R11 interrupts masked
        wr(2'd2, 8'h05);
        ext_bits(8'h3c, 8);
        check_flags("R11 full", 1'b0, 2'b01);
        ext_bits(8'hc3, 8);
        check_flags("R11 ovr", 1'b0, 2'b11);
        wr(2'd1, 8'h00);

        // R10 disabled and cut-short frames
        wr(2'd2, 8'h04);
        ext_bits(8'hff, 8);
        check_flags("R10 disabled", 1'b0, 2'b00);
        wr(2'd2, 8'h05);
        ext_bits(8'hff, 4);
        wr(2'd2, 8'h04);
        wr(2'd2, 8'h05);
        b1 = 8'h96;
        ext_bits(b1, 8);
        rd(2'd0, v); check("R10 restart", v, b1);
        wr(2'd2, 8'h04);
        wr(2'd1, 8'h00);

        // R3 internal divider periods
        for (int k = 0; k < 3; k++) begin
            int d;
            int n;
            d = 2 + int'($urandom % 4);
            wr(2'd3, 8'(d));
            wr(2'd2, 8'h03);
            wait_sck(1'b0);
            n = 0;
            do begin @(negedge clk); n++; end while (sck_out == 1'b0 && n < 100);
            check("R3 low half", n, d + 1);
            n = 0;
            do begin @(negedge clk); n++; end while (sck_out == 1'b1 && n < 100);
            check("R3 high half", n, d + 1);
            wr(2'd2, 8'h00);
            repeat (3) @(negedge clk);
            check("R3 idle", sck_out, 1'b1);
        end

        // R2 R4 internal clock frame
        wr(2'd3, 8'd2);
        wr(2'd2, 8'h03);
        b1 = 8'($urandom);
        int_frame(b1);
        wr(2'd2, 8'h00);
        rd(2'd0, v); check("R2 internal data", v, b1);
        check_flags("R4 internal", 1'b0, 2'b01);
        wr(2'd1, 8'h00);

        // R6 R8 internal back-to-back overrun stops clock
        wr(2'd2, 8'h03);
        b1 = 8'($urandom);
        b2 = 8'($urandom);
        int_frame(b1);
        int_frame(b2);
        repeat (2) @(negedge clk);
        rd(2'd0, v); check("R6 internal data kept", v, b1);
        check_flags("R6 internal", 1'b1, 2'b11);
        begin
            int lows = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (sck_out == 1'b0) lows++;
            end
            check("R8 clock stopped", lows, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule